// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

A bus-attached timer with a parameterised number of independent 32-bit channels. Each channel counts down from a programmed interval on a tick derived from one of four source tick-enable inputs, passed through a power-of-two prescaler. When a channel's count is zero and one more tick arrives, the channel expires. In periodic mode it then reloads from its interval register. In one-shot mode it halts at zero and clears its own enable bit.

Every expiry sets a sticky per-channel status bit, which software clears by writing a 1 to it. A shared interrupt-enable register masks the status bits onto a single level interrupt.

Stopping a channel is deliberately lazy. After software clears the enable bit, the channel keeps counting through a fixed number of further source ticks before it halts. This matches a counter that lives in a slower clock domain. Source clocks are modelled as single-cycle tick-enable pulses on the system clock.

Top module: `multi_timer`

## Requirements
- R1: The register map uses byte offsets. Interrupt enable is at 0x00 and interrupt status is at 0x04. Channel n has its control register at 0x10*n+0x10, its interval register at 0x10*n+0x14 and its current count at 0x10*n+0x18. Read data is registered and appears one clock after the read request. Unmapped offsets read as 0.
- R2: The control register fields are: bit 0 enable, bit 1 reload strobe, bits 3:2 source select, bits 6:4 prescale exponent, bit 7 one-shot (1) or periodic (0). A write with bit 1 set copies the interval into the counter at that write edge. Bit 1 always reads back 0.
- R3: While running, the counter decrements by one per prescaled tick. Only the src_tick_i bit chosen by the source-select field drives the channel.
- R4: A prescale exponent p produces one counter step for every 2^p ticks of the selected source, counted from the enable.
- R5: A tick arriving at count 0 is an expiry and sets the channel's status bit. In periodic mode the count reloads from the interval, giving interval+1 ticks per period. An interval of all ones runs as a free-running wrapping counter.
- R6: On a one-shot expiry the enable bit reads 0 and the count stays at 0 under further ticks.
- R7: After the enable bit is written to 0, the channel still counts the next 2 selected source ticks. After that it stops.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: irq_o is high exactly when some channel has both its status bit and its enable bit set.
- R10: Writing the interval register does not alter a running count. The new value takes effect on the next reload or periodic expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_tick_i | input | 4 | Per-source tick enables |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write (1) or read (0) |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is the lazy stop. The channel has to be running, then receive a disable write, then see exactly the right number of later source ticks. Only after that can its frozen count be read. The stimulus runs a channel for a known number of ticks, clears the enable, sends four more ticks on the selected source and reads the count back. The count must have moved by exactly two.

The prescaler boundary is reached in a similar way. Tick bursts are sized one short of, and then exactly at, a multiple of 2^p.

// File: rtl/multi_timer_pkg.sv
package multi_timer_pkg;
  localparam int unsigned SRC_W = 2;
  localparam int unsigned PRE_W = 3;
  localparam int unsigned NSRC  = 1 << SRC_W;
  localparam int unsigned CTRL_W = 3 + SRC_W + PRE_W;

  typedef struct packed {
    logic             oneshot;
    logic [PRE_W-1:0] pre;
    logic [SRC_W-1:0] src;
    logic             reload;
    logic             en;
  } ctrl_t;

  localparam logic [7:0] OFF_IEN = 8'h00;
  localparam logic [7:0] OFF_STS = 8'h04;
  localparam int unsigned CH_STRIDE = 16;
  localparam int unsigned CH_BASE   = 16;
  localparam int unsigned SUB_IVAL  = 4;
  localparam int unsigned SUB_CNT   = 8;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import multi_timer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic             tick_o
);
  localparam int unsigned PCNT_W = (1 << PRE_W) - 1;

  logic [PCNT_W-1:0] pcnt_q, mask;

  assign mask   = ~({PCNT_W{1'b1}} << pre_i);
  assign tick_o = run_i & tick_i & ((pcnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pcnt_q <= '0;
    else if (!run_i) pcnt_q <= '0;
    else if (tick_i) pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_stop_delay.sv
module tmr_stop_delay #(
  parameter int unsigned STOP_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic cancel_i,
  input  logic tick_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(STOP_TICKS + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign busy_o = busy_q;
  assign done_o = busy_q & tick_i & ~arm_i & ~cancel_i & (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (arm_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(STOP_TICKS);
    end else if (cancel_i) begin
      busy_q <= 1'b0;
    end else if (busy_q && tick_i) begin
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import multi_timer_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned STOP_TICKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_tick_i,
  input  logic              ctrl_we_i,
  input  logic              ival_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] ival_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic              expire_o
);
  ctrl_t             ctrl_q, wr_ctrl, wr_store;
  logic [DATA_W-1:0] ival_q, cnt_q;
  logic              run_q, sel_tick, ptick, expire;
  logic              arm, cancel, stop_busy, stop_done;

  assign wr_ctrl  = ctrl_t'(wdata_i[CTRL_W-1:0]);
  always_comb begin
    wr_store        = wr_ctrl;
    wr_store.reload = 1'b0;
  end

  assign sel_tick = src_tick_i[ctrl_q.src];
  assign arm      = ctrl_we_i & ~wr_ctrl.en & ctrl_q.en & run_q;
  assign cancel   = ctrl_we_i & wr_ctrl.en;
  assign expire   = run_q & ptick & (cnt_q == '0);

  tmr_prescale i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .tick_i (sel_tick),
    .pre_i  (ctrl_q.pre),
    .tick_o (ptick)
  );

  tmr_stop_delay #(.STOP_TICKS(STOP_TICKS)) i_stop (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm),
    .cancel_i (cancel),
    .tick_i   (sel_tick),
    .busy_o   (stop_busy),
    .done_o   (stop_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      run_q  <= 1'b0;
    end else begin
      if (expire && ctrl_q.oneshot) begin
        ctrl_q.en <= 1'b0;
        run_q     <= 1'b0;
      end
      if (stop_done) run_q <= 1'b0;
      if (ctrl_we_i) begin
        ctrl_q <= wr_store;
        if (wr_ctrl.en) run_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ival_q <= '0;
    else if (ival_we_i) ival_q <= wdata_i;
  end

  // reload strobe wins over a tick in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (ctrl_we_i && wr_ctrl.reload) cnt_q <= ival_q;
    else if (run_q && ptick) begin
      if (cnt_q != '0)          cnt_q <= cnt_q - 1'b1;
      else if (!ctrl_q.oneshot) cnt_q <= ival_q;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign ival_o   = ival_q;
  assign cnt_o    = cnt_q;
  assign expire_o = expire;

  logic unused_busy;
  assign unused_busy = stop_busy;
endmodule

// File: rtl/multi_timer.sv
module multi_timer
  import multi_timer_pkg::*;
#(
  parameter int unsigned NCH        = 2,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned STOP_TICKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic wr, rd;
  logic [NCH-1:0] ien_q, sts_q, expire, sts_clr;
  logic [NCH-1:0][CTRL_W-1:0] ctrl_w;
  logic [NCH-1:0][DATA_W-1:0] ival_w, cnt_w;
  logic [DATA_W-1:0] rd_mux;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CH_BASE + CH_STRIDE * i);
    tmr_channel #(.DATA_W(DATA_W), .STOP_TICKS(STOP_TICKS)) i_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_tick_i (src_tick_i),
      .ctrl_we_i  (wr && addr_i == BASE),
      .ival_we_i  (wr && addr_i == BASE + ADDR_W'(SUB_IVAL)),
      .wdata_i    (wdata_i),
      .ctrl_o     (ctrl_w[i]),
      .ival_o     (ival_w[i]),
      .cnt_o      (cnt_w[i]),
      .expire_o   (expire[i])
    );
  end

  assign sts_clr = (wr && addr_i == ADDR_W'(OFF_STS)) ? wdata_i[NCH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      sts_q <= '0;
    end else begin
      if (wr && addr_i == ADDR_W'(OFF_IEN)) ien_q <= wdata_i[NCH-1:0];
      sts_q <= (sts_q & ~sts_clr) | expire;  // a new expiry beats a clear
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(OFF_IEN)) rd_mux = DATA_W'(ien_q);
    if (addr_i == ADDR_W'(OFF_STS)) rd_mux = DATA_W'(sts_q);
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == ADDR_W'(CH_BASE + CH_STRIDE * i))            rd_mux = DATA_W'(ctrl_w[i]);
      if (addr_i == ADDR_W'(CH_BASE + CH_STRIDE * i + SUB_IVAL)) rd_mux = ival_w[i];
      if (addr_i == ADDR_W'(CH_BASE + CH_STRIDE * i + SUB_CNT))  rd_mux = cnt_w[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_mux;
  end

  assign irq_o = |(sts_q & ien_q);
endmodule

// File: rtl/multi_timer_checker.sv
module multi_timer_checker
  import multi_timer_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_i,
  input logic                       we_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [NCH-1:0]             wbits_i,
  input logic                       irq_o,
  input logic [NCH-1:0]             ien_q,
  input logic [NCH-1:0]             sts_q,
  input logic [NCH-1:0]             expire,
  input logic [NCH-1:0][CTRL_W-1:0] ctrl_w,
  input logic [NCH-1:0][DATA_W-1:0] ival_w,
  input logic [NCH-1:0][DATA_W-1:0] cnt_w
);
  logic wr;
  assign wr = req_i & we_i;

  AST_IRQ_NO_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o); // R9
  AST_IRQ_NO_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q == '0) |-> !irq_o); // R9

  for (genvar i = 0; i < NCH; i++) begin : g_a
    localparam logic [ADDR_W-1:0] CB = ADDR_W'(CH_BASE + CH_STRIDE * i);
    logic ctrl_wr, any_wr;
    assign ctrl_wr = wr && addr_i == CB;
    assign any_wr  = ctrl_wr || (wr && addr_i == CB + ADDR_W'(SUB_IVAL));

    AST_EXPIRE_SETS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire[i] |=> sts_q[i]); // R5
    AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sts_q[i] && !(wr && addr_i == ADDR_W'(OFF_STS) && wbits_i[i]) |=> sts_q[i]); // R8
    AST_ONESHOT_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire[i] && ctrl_w[i][CTRL_W-1] && !ctrl_wr |=> !ctrl_w[i][0] && cnt_w[i] == '0); // R6
    AST_PERIODIC_RELOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire[i] && !ctrl_w[i][CTRL_W-1] && !any_wr |=> cnt_w[i] == $past(ival_w[i])); // R5
    AST_COUNT_STEPS_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_wr && !expire[i] |=> cnt_w[i] == $past(cnt_w[i]) || cnt_w[i] == $past(cnt_w[i]) - 1'b1); // R3
    AST_CTRL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_wr && !expire[i] |=> $stable(ctrl_w[i])); // R2
  end
endmodule

bind multi_timer multi_timer_checker #(.NCH(NCH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wbits_i (wdata_i[NCH-1:0]),
  .irq_o   (irq_o),
  .ien_q   (ien_q),
  .sts_q   (sts_q),
  .expire  (expire),
  .ctrl_w  (ctrl_w),
  .ival_w  (ival_w),
  .cnt_w   (cnt_w)
);

// File: tb/test_multi_timer.sv
`timescale 1ns/1ps
module test_multi_timer;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    src_tick = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  always #4 clk = ~clk;

  multi_timer i_multi_timer (
    .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src_tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic [DW-1:0] exp_v;
  string         tag_v;
  logic          mon_rd = 1'b0;

  always @(posedge clk) mon_rd <= req & ~we;

  // monitor: compare each registered read result against the queued expectation
  always @(negedge clk) begin
    if (mon_rd) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL read with no expectation: actual %h expected none", rdata);
      end else begin
        exp_v = exp_q.pop_front();
        tag_v = tag_q.pop_front();
        if (rdata !== exp_v) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", tag_v, rdata, exp_v);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
    @(negedge clk); exp_q.push_back(e); tag_q.push_back(t);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic tick(input int s, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); src_tick = 4'(1 << s);
      @(negedge clk); src_tick = '0;
    end
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state and map
    rd(8'h00, 32'h0, "R1 ien reset");
    rd(8'h04, 32'h0, "R1 sts reset");
    rd(8'h10, 32'h0, "R1 ctrl0 reset");
    rd(8'h18, 32'h0, "R1 cnt0 reset");
    rd(8'h24, 32'h0, "R1 ival1 reset");
    chk_irq(1'b0, "R9 irq reset");
    // R2 reload strobe, R3 counting and source select
    wr(8'h14, 32'd10);
    wr(8'h10, 32'h03);
    rd(8'h14, 32'd10, "R1 ival0 readback");
    rd(8'h18, 32'd10, "R2 reload copies interval");
    rd(8'h10, 32'h01, "R2 reload bit reads 0");
    tick(0, 3);
    rd(8'h18, 32'd7, "R3 count down");
    tick(1, 2);
    rd(8'h18, 32'd7, "R3 unselected source ignored");
    // R10 interval write during run, R5 periodic expiry
    wr(8'h14, 32'd50);
    rd(8'h18, 32'd7, "R10 running count unchanged");
    tick(0, 7);
    rd(8'h18, 32'd0, "R5 reached zero");
    rd(8'h04, 32'h0, "R5 no expiry at zero");
    tick(0, 1);
    rd(8'h18, 32'd50, "R5 R10 periodic reload");
    rd(8'h04, 32'h1, "R5 status set");
    chk_irq(1'b0, "R9 masked");
    wr(8'h00, 32'h1);
    chk_irq(1'b1, "R9 enabled");
    wr(8'h04, 32'h0);
    rd(8'h04, 32'h1, "R8 write 0 keeps status");
    wr(8'h04, 32'h1);
    rd(8'h04, 32'h0, "R8 write 1 clears");
    chk_irq(1'b0, "R9 cleared");
    // R7 lazy stop
    tick(0, 5);
    rd(8'h18, 32'd45, "R7 before disable");
    wr(8'h10, 32'h00);
    tick(0, 4);
    rd(8'h18, 32'd43, "R7 two ticks after disable");
    rd(8'h10, 32'h00, "R7 ctrl disabled");
    // R6 one-shot on channel 1, source 1
    wr(8'h24, 32'd2);
    wr(8'h20, 32'h87);
    tick(1, 3);
    rd(8'h04, 32'h2, "R6 one-shot status");
    rd(8'h20, 32'h84, "R6 enable self-clears");
    tick(1, 2);
    rd(8'h28, 32'd0, "R6 holds at zero");
    chk_irq(1'b0, "R9 other channel masked");
    wr(8'h00, 32'h3);
    chk_irq(1'b1, "R9 channel 1 enabled");
    wr(8'h04, 32'h2);
    chk_irq(1'b0, "R9 channel 1 cleared");
    // R4 prescale exponent 2 on source 1
    wr(8'h24, 32'd100);
    wr(8'h20, 32'h27);
    tick(1, 8);
    rd(8'h28, 32'd98, "R4 divide by 4");
    tick(1, 3);
    rd(8'h28, 32'd98, "R4 partial group");
    tick(1, 1);
    rd(8'h28, 32'd97, "R4 group complete");
    // R5 all-ones interval, and zero interval
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h10, 32'h03);
    tick(0, 1);
    rd(8'h18, 32'hFFFF_FFFE, "R5 all-ones interval");
    wr(8'h14, 32'd0);
    wr(8'h10, 32'h03);
    tick(0, 1);
    rd(8'h04, 32'h1, "R5 zero interval expires each tick");
    rd(8'h18, 32'd0, "R5 zero interval reload");
    rd(8'h0C, 32'h0, "R1 unmapped offset");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R1 pending reads: actual %0d expected 0", exp_q.size());
    end
    summary();
  end
endmodule